// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the last stage of a binary32 floating-point datapath. The arithmetic stage in front of it hands over an unpacked result: a sign, a signed unbiased exponent and a 27-bit significand. The significand holds the hidden bit, 23 fraction bits and three extra low bits (guard, round and sticky). The unit returns the final 32-bit word and three exception flags: inexact, underflow and overflow.

The unit makes the result tiny when the exponent is too small, either by shifting right with sticky collection or by flushing to zero when that is enabled. It rounds in one of four directed modes. It renormalises when rounding carries out of the significand. It saturates to infinity or to the largest finite value on overflow, and it encodes subnormals with a zero exponent field. A result exactly at the smallest normal exponent minus one that rounds up into the normal range is treated as not tiny. The unit has one register stage, and results come out one cycle after they go in.

The exponent input is a two's-complement number. Mode encoding on `rnd_mode_i`: 0 = round to nearest, ties to even; 1 = toward zero; 2 = toward plus infinity; 3 = toward minus infinity.

Top module: `rp_round_pack`

## Requirements
- R1: While reset is asserted, `out_valid_o`, the word and all flags are 0. Each accepted input produces `out_valid_o` high with its result on the following clock cycle, and the unit produces no output for cycles with `in_valid_i` low.
- R2: With the low three significand bits zero and the exponent e in -126..127, the word is {sign, e+127 in bits 30:23, significand bits 25:3 in bits 22:0}, and no flag is set.
- R3: When any of the low three bits is nonzero, the unit raises inexact and adds an increment to the significand before truncating the low three bits. The increment is 3 plus bit 3 in mode 0, nothing in mode 1, 8 for a positive sign in mode 2, and 8 for a negative sign in mode 3.
- R4: If rounding carries out of bit 26, the significand shifts right by one and the exponent increases by one.
- R5: If the exponent after rounding exceeds 127, overflow and inexact are raised. The magnitude is infinity (0x7F800000) in mode 0, in mode 2 for positive values and in mode 3 for negative values. In every other case it is the largest finite value (0x7F7FFFFF). The sign is kept in all cases.
- R6: With `ftz_en_i` set and an exponent below -126, underflow and inexact are raised. The result is a signed zero, except that mode 2 with a positive sign gives 0x00000001 and mode 3 with a negative sign gives 0x80000001.
- R7: Without flush, take an exponent of exactly -127 whose rounding carries out of bit 26. The result is the smallest normal of that sign (exponent field 1, fraction 0). Only inexact is raised.
- R8: Without flush, in every other case with an exponent below -126, the significand is shifted right by (-126 - e), with shifted-out ones ORed into bit 0. The result packs with exponent field 0. If the shifted low bits are nonzero, inexact and underflow are raised.
- R9: A shift of 27 or more leaves only the sticky bit, so the result is zero or the smallest subnormal, chosen by the rounding mode and the sign.
- R10: An exact subnormal result raises underflow only when `uf_trap_en_i` is set. It raises no flag otherwise. A normal exact result raises no flag in either case.
- R11: When a subnormal rounds up into bit 26, the result packs with exponent field 1. Underflow is still raised, because the value was tiny before rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input qualifier |
| in_sign_i | input | 1 | Sign of the unpacked value |
| in_exp_i | input | 10 | Unbiased exponent, two's complement |
| in_sig_i | input | 27 | Hidden bit, 23 fraction bits, 3 low rounding bits |
| rnd_mode_i | input | 2 | Rounding mode (0 near-even, 1 zero, 2 up, 3 down) |
| ftz_en_i | input | 1 | Flush tiny results to zero or smallest subnormal |
| uf_trap_en_i | input | 1 | Report underflow on exact subnormal results |
| out_valid_o | output | 1 | Result qualifier |
| out_word_o | output | 32 | Packed binary32 result |
| out_inexact_o | output | 1 | Inexact flag |
| out_underflow_o | output | 1 | Underflow flag |
| out_overflow_o | output | 1 | Overflow flag |

## Verification
The assertions take as given that every valid input carries its hidden bit (bit 26) set. They also assume the input is never a zero, NaN or infinity, which the upstream stage must handle itself. The output checks on flags and the exponent field hold only under this contract. For example, they rely on the hidden bit being set when the unit concludes that an overflowing value was not tiny. The stimulus builds every significand through a helper that forces bit 26 to one, and it picks exponents inside the 10-bit signed range. Those exponents run from large positive values down to -300, so the saturating shift is reached.

// File: rtl/rp_pkg.sv
package rp_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rp_rmode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
    } rp_flags_t;

endpackage

// File: rtl/rp_sticky_shift.sv
module rp_sticky_shift #(
    parameter int SIG_W   = 27,
    parameter int SHAMT_W = $clog2(SIG_W)
) (
    input  logic [SIG_W-1:0]   sig_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               sat_i,
    output logic [SIG_W-1:0]   sig_o
);
    logic [SIG_W-1:0] stg [SHAMT_W+1];

    assign stg[0] = sig_i;

    // log-depth shifter: every stage folds the bits it drops into bit 0
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [SIG_W-1:0] moved;
        assign moved = (stg[k] >> STEP) | {{(SIG_W-1){1'b0}}, |stg[k][STEP-1:0]};
        assign stg[k+1] = shamt_i[k] ? moved : stg[k];
    end

    always_comb begin
        if (sat_i) begin
            sig_o = {{(SIG_W-1){1'b0}}, |sig_i};
        end else begin
            sig_o = stg[SHAMT_W];
        end
    end

    // R8: a nonzero significand never vanishes through the shift
    always_comb begin
        sticky_keep_chk: assert (!(|sig_i) || (|sig_o));
    end

endmodule

// File: rtl/rp_round_inc.sv
module rp_round_inc
    import rp_pkg::*;
#(
    parameter int SIG_W = 27,
    parameter int GRS   = 3
) (
    input  logic             sign_i,
    input  rp_rmode_e        mode_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic [SIG_W:0]   sum_o,
    output logic             lost_o
);
    logic [SIG_W:0] inc;

    assign lost_o = |sig_i[GRS-1:0];

    always_comb begin
        inc = '0;
        if (lost_o) begin
            unique case (mode_i)
                RM_NEAR: begin
                    inc[GRS-1:0] = {GRS{1'b1}} >> 1;
                    inc = inc + {{SIG_W{1'b0}}, sig_i[GRS]};
                end
                RM_ZERO: inc = '0;
                RM_UP:   inc[GRS] = ~sign_i;
                RM_DOWN: inc[GRS] = sign_i;
                default: inc = '0;
            endcase
        end
    end

    assign sum_o = {1'b0, sig_i} + inc;

    // R3: an exact significand passes through unchanged
    always_comb begin
        exact_pass_chk: assert (lost_o || (sum_o == {1'b0, sig_i}));
    end

endmodule

// File: rtl/rp_sat_word.sv
module rp_sat_word
    import rp_pkg::*;
#(
    parameter int EF_W   = 8,
    parameter int FRAC_W = 23,
    parameter int WORD_W = 1 + EF_W + FRAC_W
) (
    input  logic              sign_i,
    input  rp_rmode_e         mode_i,
    output logic [WORD_W-1:0] ftz_word_o,
    output logic [WORD_W-1:0] ovf_word_o
);
    localparam logic [WORD_W-2:0] MAG_INF = {{EF_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-2:0] MAG_MAX = {{(EF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    localparam logic [WORD_W-2:0] MAG_MIN = {{(WORD_W-2){1'b0}}, 1'b1};

    logic away;

    // away from zero in the direction of the sign
    assign away = ((mode_i == RM_UP) && !sign_i) || ((mode_i == RM_DOWN) && sign_i);

    always_comb begin
        ftz_word_o = {sign_i, away ? MAG_MIN : {(WORD_W-1){1'b0}}};
        ovf_word_o = {sign_i, (away || (mode_i == RM_NEAR)) ? MAG_INF : MAG_MAX};
    end

endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack
    import rp_pkg::*;
#(
    parameter int EXP_W  = 10,
    parameter int EF_W   = 8,
    parameter int FRAC_W = 23,
    parameter int GRS    = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 in_valid_i,
    input  logic                 in_sign_i,
    input  logic [EXP_W-1:0]     in_exp_i,
    input  logic [FRAC_W+GRS:0]  in_sig_i,
    input  logic [1:0]           rnd_mode_i,
    input  logic                 ftz_en_i,
    input  logic                 uf_trap_en_i,
    output logic                 out_valid_o,
    output logic [EF_W+FRAC_W:0] out_word_o,
    output logic                 out_inexact_o,
    output logic                 out_underflow_o,
    output logic                 out_overflow_o
);
    localparam int SIG_W   = FRAC_W + 1 + GRS;
    localparam int WORD_W  = 1 + EF_W + FRAC_W;
    localparam int XW      = EXP_W + 2;
    localparam int SHAMT_W = $clog2(SIG_W);
    localparam int BIAS    = (1 << (EF_W - 1)) - 1;
    localparam logic signed [XW-1:0] EMIN_X = XW'(1 - BIAS);
    localparam logic signed [XW-1:0] EMAX_X = XW'(BIAS);
    localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);
    localparam logic signed [XW-1:0] SIG_X  = XW'(SIG_W);
    localparam logic [SIG_W-1:0]     GRS_MASK = {{(SIG_W-GRS){1'b0}}, {GRS{1'b1}}};

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        rp_flags_t         flags;
    } stage_t;

    stage_t stage_d, stage_q;

    rp_rmode_e          mode;
    logic signed [XW-1:0] xe, es, xe_a, xe_c, ef_full;
    logic               below, at_m1, sat, nt_hit;
    logic [SIG_W-1:0]   shifted, sig_a, sig_c;
    logic [SIG_W:0]     pre_sum, post_sum;
    logic               pre_lost, post_lost;
    logic [WORD_W-1:0]  ftz_word, ovf_word;
    logic [FRAC_W:0]    mant;
    logic               unused_bits;

    assign mode  = rp_rmode_e'(rnd_mode_i);
    assign xe    = {{2{in_exp_i[EXP_W-1]}}, in_exp_i};
    assign below = xe < EMIN_X;
    assign at_m1 = xe == (EMIN_X - XW'(1));
    assign es    = EMIN_X - xe;
    assign sat   = es >= SIG_X;

    rp_sticky_shift #(.SIG_W(SIG_W), .SHAMT_W(SHAMT_W)) u_shift (
        .sig_i   (in_sig_i),
        .shamt_i (es[SHAMT_W-1:0]),
        .sat_i   (sat),
        .sig_o   (shifted)
    );

    // rounding of the raw value, used only to detect "not tiny" at Emin-1
    rp_round_inc #(.SIG_W(SIG_W), .GRS(GRS)) u_pre_round (
        .sign_i (in_sign_i),
        .mode_i (mode),
        .sig_i  (in_sig_i),
        .sum_o  (pre_sum),
        .lost_o (pre_lost)
    );

    rp_sat_word #(.EF_W(EF_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W)) u_sat (
        .sign_i     (in_sign_i),
        .mode_i     (mode),
        .ftz_word_o (ftz_word),
        .ovf_word_o (ovf_word)
    );

    assign nt_hit = below && !ftz_en_i && at_m1 && pre_sum[SIG_W];

    // select the significand that enters the final rounding
    always_comb begin
        sig_a = in_sig_i;
        xe_a  = xe;
        if (nt_hit) begin
            sig_a = pre_sum[SIG_W:1] & ~GRS_MASK;
            xe_a  = EMIN_X;
        end else if (below) begin
            sig_a = shifted;
            xe_a  = EMIN_X;
        end
    end

    rp_round_inc #(.SIG_W(SIG_W), .GRS(GRS)) u_post_round (
        .sign_i (in_sign_i),
        .mode_i (mode),
        .sig_i  (sig_a),
        .sum_o  (post_sum),
        .lost_o (post_lost)
    );

    always_comb begin
        sig_c   = post_sum[SIG_W] ? post_sum[SIG_W:1] : post_sum[SIG_W-1:0];
        xe_c    = xe_a + {{(XW-1){1'b0}}, post_sum[SIG_W]};
        mant    = sig_c[SIG_W-1:GRS];
        ef_full = xe_c + BIAS_X;
    end

    assign unused_bits = ^{pre_sum[0], pre_lost, sig_c[GRS-1:0], ef_full[XW-1:EF_W]};

    always_comb begin
        stage_d       = '0;
        stage_d.valid = in_valid_i;
        if (!in_valid_i) begin
            stage_d = '0;
        end else if (below && ftz_en_i) begin
            stage_d.word            = ftz_word;
            stage_d.flags.inexact   = 1'b1;
            stage_d.flags.underflow = 1'b1;
        end else begin
            stage_d.flags.inexact   = nt_hit | post_lost;
            stage_d.flags.underflow = post_lost & ~sig_a[SIG_W-1];
            if (xe_c > EMAX_X) begin
                stage_d.word           = ovf_word;
                stage_d.flags.overflow = 1'b1;
                stage_d.flags.inexact  = 1'b1;
            end else if (!mant[FRAC_W]) begin
                stage_d.word = {in_sign_i, {EF_W{1'b0}}, mant[FRAC_W-1:0]};
                stage_d.flags.underflow = stage_d.flags.underflow | uf_trap_en_i;
            end else begin
                stage_d.word = {in_sign_i, ef_full[EF_W-1:0], mant[FRAC_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid_o     = stage_q.valid;
    assign out_word_o      = stage_q.word;
    assign out_inexact_o   = stage_q.flags.inexact;
    assign out_underflow_o = stage_q.flags.underflow;
    assign out_overflow_o  = stage_q.flags.overflow;

    // R1
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
    // R2 (input contract: hidden bit set on every valid input)
    hidden_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |-> in_sig_i[SIG_W-1]);
    // R2
    exact_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_sig_i[GRS-1:0] == '0 && !below && xe <= EMAX_X)
        |=> (out_valid_o && !out_inexact_o && !out_underflow_o && !out_overflow_o));
    // R5
    ovf_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_overflow_o) |-> out_inexact_o);
    // R5
    ovf_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_overflow_o) |->
        (out_word_o[WORD_W-2:FRAC_W] == {EF_W{1'b1}} && out_word_o[FRAC_W-1:0] == '0) ||
        (out_word_o[WORD_W-2:FRAC_W] == {{(EF_W-1){1'b1}}, 1'b0} &&
         out_word_o[FRAC_W-1:0] == {FRAC_W{1'b1}}));
    // R8
    uf_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_underflow_o) |->
        (!out_overflow_o && out_word_o[WORD_W-2:FRAC_W] <= EF_W'(1)));
    // R5
    nan_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |->
        !(out_word_o[WORD_W-2:FRAC_W] == {EF_W{1'b1}} && out_word_o[FRAC_W-1:0] != '0));

endmodule

// File: tb/test_rp_round_pack.sv
`timescale 1ns/1ps
module test_rp_round_pack;

    localparam logic [1:0] M_NE = 2'd0;
    localparam logic [1:0] M_TZ = 2'd1;
    localparam logic [1:0] M_UP = 2'd2;
    localparam logic [1:0] M_DN = 2'd3;

    typedef struct {
        logic [31:0] word;
        logic [2:0]  fl;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [9:0]  in_exp = '0;
    logic [26:0] in_sig = '0;
    logic [1:0]  mode = '0;
    logic        ftz = 1'b0;
    logic        ute = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_ix, out_uf, out_ov;

    item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rp_round_pack i_rp_round_pack (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .in_valid_i      (in_valid),
        .in_sign_i       (in_sign),
        .in_exp_i        (in_exp),
        .in_sig_i        (in_sig),
        .rnd_mode_i      (mode),
        .ftz_en_i        (ftz),
        .uf_trap_en_i    (ute),
        .out_valid_o     (out_valid),
        .out_word_o      (out_word),
        .out_inexact_o   (out_ix),
        .out_underflow_o (out_uf),
        .out_overflow_o  (out_ov)
    );

    function automatic logic [26:0] mk(input logic [22:0] frac, input logic [2:0] low);
        return {1'b1, frac, low};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [35:0] act,
                         input logic [35:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // flags vector {inexact, underflow, overflow}
    task automatic send(input logic s, input int e, input logic [26:0] sig,
                        input logic [1:0] m, input logic f, input logic u,
                        input logic [31:0] w, input logic [2:0] fl, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_sign  = s;
        in_exp   = 10'(e);
        in_sig   = sig;
        mode     = m;
        ftz      = f;
        ute      = u;
        it.word = w;
        it.fl   = fl;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    // monitor: pop and compare each result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected output", {4'h0, out_word}, '0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(out_word == it.word, {it.tag, " word"}, {4'h0, out_word}, {4'h0, it.word});
                check({out_ix, out_uf, out_ov} == it.fl, {it.tag, " flags"},
                      {33'h0, out_ix, out_uf, out_ov}, {33'h0, it.fl});
            end
        end
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", '0, 36'h1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({out_valid, out_word, out_ix, out_uf, out_ov} == '0, "R1 reset state",
              {out_valid, out_word, out_ix, out_uf, out_ov}, '0);
        rst_n = 1'b1;

        // R2 exact normals
        send(0, 0,   mk(23'h0, 3'b000),      M_NE, 0, 0, 32'h3F800000, 3'b000, "R2 one");
        send(1, 3,   mk(23'h123456, 3'b000), M_NE, 0, 0, 32'hC1123456, 3'b000, "R2 neg");
        // R3 rounding modes
        send(0, 0, mk(23'h0, 3'b100), M_NE, 0, 0, 32'h3F800000, 3'b100, "R3 tie even down");
        send(0, 0, mk(23'h1, 3'b100), M_NE, 0, 0, 32'h3F800002, 3'b100, "R3 tie odd up");
        send(0, 0, mk(23'h0, 3'b101), M_NE, 0, 0, 32'h3F800001, 3'b100, "R3 above half");
        send(0, 0, mk(23'h5, 3'b111), M_TZ, 0, 0, 32'h3F800005, 3'b100, "R3 toward zero");
        send(0, 0, mk(23'h5, 3'b001), M_UP, 0, 0, 32'h3F800006, 3'b100, "R3 up pos");
        send(1, 0, mk(23'h5, 3'b001), M_UP, 0, 0, 32'hBF800005, 3'b100, "R3 up neg");
        send(1, 0, mk(23'h5, 3'b001), M_DN, 0, 0, 32'hBF800006, 3'b100, "R3 down neg");
        send(0, 0, mk(23'h5, 3'b001), M_DN, 0, 0, 32'h3F800005, 3'b100, "R3 down pos");
        // R4 carry renormalisation
        send(0, 0, mk(23'h7FFFFF, 3'b100), M_NE, 0, 0, 32'h40000000, 3'b100, "R4 carry");
        // R5 overflow table
        send(0, 128, mk(23'h0, 3'b000), M_NE, 0, 0, 32'h7F800000, 3'b101, "R5 near pos");
        send(1, 128, mk(23'h0, 3'b000), M_TZ, 0, 0, 32'hFF7FFFFF, 3'b101, "R5 zero neg");
        send(0, 128, mk(23'h0, 3'b000), M_UP, 0, 0, 32'h7F800000, 3'b101, "R5 up pos");
        send(1, 128, mk(23'h0, 3'b000), M_UP, 0, 0, 32'hFF7FFFFF, 3'b101, "R5 up neg");
        send(0, 128, mk(23'h0, 3'b000), M_DN, 0, 0, 32'h7F7FFFFF, 3'b101, "R5 down pos");
        send(1, 128, mk(23'h0, 3'b000), M_DN, 0, 0, 32'hFF800000, 3'b101, "R5 down neg");
        send(0, 127, mk(23'h7FFFFF, 3'b111), M_NE, 0, 0, 32'h7F800000, 3'b101, "R5 via carry");
        send(0, 127, mk(23'h7FFFFF, 3'b111), M_TZ, 0, 0, 32'h7F7FFFFF, 3'b100, "R5 max no carry");
        // R6 flush to zero
        send(0, -127, mk(23'h0, 3'b000), M_NE, 1, 0, 32'h00000000, 3'b110, "R6 near pos");
        send(1, -127, mk(23'h0, 3'b000), M_TZ, 1, 0, 32'h80000000, 3'b110, "R6 zero neg");
        send(0, -127, mk(23'h0, 3'b000), M_UP, 1, 0, 32'h00000001, 3'b110, "R6 up pos");
        send(1, -127, mk(23'h0, 3'b000), M_UP, 1, 0, 32'h80000000, 3'b110, "R6 up neg");
        send(0, -127, mk(23'h0, 3'b000), M_DN, 1, 0, 32'h00000000, 3'b110, "R6 down pos");
        send(1, -127, mk(23'h0, 3'b000), M_DN, 1, 0, 32'h80000001, 3'b110, "R6 down neg");
        send(0, -127, mk(23'h7FFFFF, 3'b100), M_NE, 1, 0, 32'h00000000, 3'b110, "R6 over not-tiny");
        // R7 not tiny after rounding
        send(0, -127, mk(23'h7FFFFF, 3'b100), M_NE, 0, 0, 32'h00800000, 3'b100, "R7 near");
        send(1, -127, mk(23'h7FFFFF, 3'b001), M_DN, 0, 0, 32'h80800000, 3'b100, "R7 down neg");
        // R8 denormalisation
        send(0, -127, mk(23'h0, 3'b001), M_NE, 0, 0, 32'h00400000, 3'b110, "R8 sticky near");
        send(0, -127, mk(23'h0, 3'b001), M_UP, 0, 0, 32'h00400001, 3'b110, "R8 sticky up");
        send(0, -129, mk(23'h0, 3'b000), M_NE, 0, 0, 32'h00100000, 3'b000, "R8 exact shift3");
        // R10 exact tiny and trap enable
        send(0, -127, mk(23'h0, 3'b000), M_NE, 0, 0, 32'h00400000, 3'b000, "R10 no trap");
        send(0, -127, mk(23'h0, 3'b000), M_NE, 0, 1, 32'h00400000, 3'b010, "R10 trap");
        send(0, -126, mk(23'h0, 3'b000), M_NE, 0, 1, 32'h00800000, 3'b000, "R10 normal trap");
        // R9 saturated shift
        send(1, -152, mk(23'h0, 3'b000), M_TZ, 0, 0, 32'h80000000, 3'b110, "R9 shift26");
        send(0, -153, mk(23'h0, 3'b000), M_UP, 0, 0, 32'h00000001, 3'b110, "R9 shift27 up");
        send(0, -300, mk(23'h0, 3'b000), M_NE, 0, 0, 32'h00000000, 3'b110, "R9 deep near");
        send(1, -300, mk(23'h7FFFFF, 3'b111), M_DN, 0, 0, 32'h80000001, 3'b110, "R9 deep down");
        // R11 subnormal rounding into the hidden bit
        send(0, -127, mk(23'h7FFFFF, 3'b000), M_NE, 0, 0, 32'h00800000, 3'b110, "R11 carry");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R1: no output when idle, every item delivered
        check(!out_valid, "R1 idle", {35'h0, out_valid}, '0);
        check(exp_q.size() == 0, "R1 all delivered", 36'(exp_q.size()), '0);
        done = 1'b1;
        finish_run();
    end

endmodule